// File: doc/BRIEF.md
# Masked-Pin Serial Byte Writer

This block drives a serial bit stream through two groups of pins that belong to a wider parallel output port. A configuration word picks which low port pins carry the serial clock and which carry the data, and whether each byte goes out most-significant bit first or least-significant bit first. The configuration is checked against a build-time mask of pins the block may change and against the port's live output-enable bits. A configuration that fails the check leaves the block with no pins selected.

Once configured, the block takes bytes on a valid/ready input. Each bit goes through three phases: clock pins low, data pins set to the bit value, clock pins high. Each phase lasts a programmable number of system clock cycles, so data is held steady for a full phase before the clock edge rises. All other port bits keep their values. While the block is idle, a plain write input can load the whole port.

The byte input follows the usual valid/ready rule. A byte moves only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a byte is being shifted, except in the final cycle of the last clock-high phase, so a waiting byte follows with no gap. `in_ready` is also low in any cycle where `cfg_valid` is high. A byte that arrives while no pins are selected is taken and then dropped, with an error pulse.

Top module: `port_serial_writer`

## Requirements
- R1: After reset `port_dout` equals `RESET_VAL` (default 0), `busy` and `err` are 0, `in_ready` is 1, and both pin masks are zero.
- R2: A configuration word has the clock mask in bits 7:0, the data mask in bits 15:8 and the MSB-first flag in bit 16. It is accepted, with `err` low, only if each mask has at least one bit in `CHG_MASK` and at least one bit set in `oe_bits`.
- R3: A configuration that fails the R2 check clears both masks and pulses `err` in the next cycle. A byte offered afterwards is refused.
- R4: A byte taken while either mask is zero is dropped. `err` pulses in the next cycle, `busy` stays 0 and `port_dout` is unchanged.
- R5: Each bit runs clock pins low, then data pins set to the bit value, then clock pins high. Each phase lasts `phase_len` cycles, and a value of 0 counts as 1.
- R6: With bit 16 set, a byte goes out bit 7 first and bit 0 last. With bit 16 clear, it goes out bit 0 first and bit 7 last.
- R7: Port bits outside the clock and data masks do not change while `busy` is high.
- R8: `busy` rises in the cycle after a byte is taken and stays high for 24×`phase_len` cycles. `in_ready` is low during that time, except in the final cycle.
- R9: A byte that is waiting at the end of a transfer is taken in that final cycle. Its clock-low phase starts in the very next cycle.
- R10: When `busy` falls, all clock pins are high.
- R11: A configuration offered while `busy` is high is ignored and pulses `err` in the next cycle.
- R12: `port_wr` loads `port_wr_val` into the port only while idle. It has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Offer a configuration word this cycle |
| cfg_word | input | 17 | Clock mask, data mask and order flag |
| oe_bits | input | PORT_W | Current port output-enable bits |
| phase_len | input | LEN_W | Cycles per phase (0 acts as 1) |
| port_wr | input | 1 | Load the whole port while idle |
| port_wr_val | input | PORT_W | Value for `port_wr` |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_byte | input | 8 | Byte to send |
| port_dout | output | PORT_W | Port output data value |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle error pulse |

## Verification
The checks on data steadiness and on untouched bits take the clock and data masks to be disjoint. They also take `phase_len` to be stable during a transfer. The bench only ever configures disjoint single-bit masks and changes `phase_len` only while idle. The properties also take it that `cfg_valid` and `port_wr` are each held for one cycle per attempt. A scoreboard rebuilds each byte from data samples taken at clock-pin rising edges and checks every cycle that the untouched bits hold their value.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int unsigned SEL_W  = 8;
  localparam int unsigned CFG_W  = 2 * SEL_W + 1;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IW = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLK_LO = 2'd1,
    PH_DATA   = 2'd2,
    PH_CLK_HI = 2'd3
  } phase_e;

  // bit 16 order flag, 15:8 data pins, 7:0 clock pins
  typedef struct packed {
    logic             msb_first;
    logic [SEL_W-1:0] dat_sel;
    logic [SEL_W-1:0] clk_sel;
  } cfg_t;
endpackage

// File: rtl/spw_cfg_reg.sv
module spw_cfg_reg
  import spw_pkg::*;
#(
  parameter int unsigned      PORT_W   = 18,
  parameter logic [PORT_W-1:0] CHG_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [PORT_W-1:0] oe_bits,
  input  logic              busy,
  output logic [SEL_W-1:0]  clk_sel,
  output logic [SEL_W-1:0]  dat_sel,
  output logic              msb_first,
  output logic              cfg_err
);
  cfg_t              req;
  logic [PORT_W-1:0] req_clk_w;
  logic [PORT_W-1:0] req_dat_w;
  logic              clk_ok;
  logic              dat_ok;
  logic              take;

  assign req       = cfg_t'(cfg_word);
  assign req_clk_w = PORT_W'(req.clk_sel);
  assign req_dat_w = PORT_W'(req.dat_sel);

  // each mask must touch a changeable pin and an enabled output
  assign clk_ok  = (|(req_clk_w & CHG_MASK)) && (|(req_clk_w & oe_bits));
  assign dat_ok  = (|(req_dat_w & CHG_MASK)) && (|(req_dat_w & oe_bits));
  assign take    = cfg_valid && !busy;
  assign cfg_err = cfg_valid && (busy || !(clk_ok && dat_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel   <= '0;
      dat_sel   <= '0;
      msb_first <= 1'b0;
    end else if (take) begin
      msb_first <= req.msb_first;
      if (clk_ok && dat_ok) begin
        clk_sel <= req.clk_sel;
        dat_sel <= req.dat_sel;
      end else begin
        clk_sel <= '0;
        dat_sel <= '0;
      end
    end
  end
endmodule

// File: rtl/spw_phase_timer.sv
module spw_phase_timer #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] left;
  logic [LEN_W-1:0] reload;

  // a zero length behaves as one cycle
  assign reload = (len == '0) ? '0 : len - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      left <= '0;
    else if (load)
      left <= reload;
    else if (left != '0)
      left <= left - LEN_W'(1);
  end

  assign done = (left == '0);
endmodule

// File: rtl/spw_bit_seq.sv
module spw_bit_seq
  import spw_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cfg_hold,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [LEN_W-1:0]  len,
  output logic              ready,
  output logic              busy,
  output logic              ent_lo,
  output logic              ent_data,
  output logic              ent_hi,
  output logic              bit_val
);
  phase_e            st;
  phase_e            st_n;
  logic [BYTE_W-1:0] shreg;
  logic [BIT_IW-1:0] bit_idx;
  logic              done;
  logic              load;
  logic              last;
  logic              fetch;
  logic              advance;

  spw_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .len   (len),
    .done  (done)
  );

  assign last    = (bit_idx == BIT_IW'(BYTE_W - 1));
  assign busy    = (st != PH_IDLE);
  assign ready   = !cfg_hold && ((st == PH_IDLE) || (st == PH_CLK_HI && last && done));
  assign bit_val = msb_first ? shreg[BYTE_W-1] : shreg[0];

  always_comb begin
    st_n     = st;
    load     = 1'b0;
    ent_lo   = 1'b0;
    ent_data = 1'b0;
    ent_hi   = 1'b0;
    fetch    = 1'b0;
    advance  = 1'b0;
    case (st)
      PH_IDLE: begin
        if (go) begin
          st_n = PH_CLK_LO; load = 1'b1; ent_lo = 1'b1; fetch = 1'b1;
        end
      end
      PH_CLK_LO: begin
        if (done) begin
          st_n = PH_DATA; load = 1'b1; ent_data = 1'b1;
        end
      end
      PH_DATA: begin
        if (done) begin
          st_n = PH_CLK_HI; load = 1'b1; ent_hi = 1'b1;
        end
      end
      PH_CLK_HI: begin
        if (done) begin
          if (!last) begin
            st_n = PH_CLK_LO; load = 1'b1; ent_lo = 1'b1; advance = 1'b1;
          end else if (go) begin
            st_n = PH_CLK_LO; load = 1'b1; ent_lo = 1'b1; fetch = 1'b1;
          end else begin
            st_n = PH_IDLE;
          end
        end
      end
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
    end else begin
      st <= st_n;
      if (fetch) begin
        shreg   <= byte_in;
        bit_idx <= '0;
      end else if (advance) begin
        shreg   <= msb_first ? {shreg[BYTE_W-2:0], 1'b0} : {1'b0, shreg[BYTE_W-1:1]};
        bit_idx <= bit_idx + BIT_IW'(1);
      end
    end
  end
endmodule

// File: rtl/port_serial_writer.sv
module port_serial_writer
  import spw_pkg::*;
#(
  parameter int unsigned       PORT_W    = 18,
  parameter int unsigned       LEN_W     = 8,
  parameter logic [PORT_W-1:0] CHG_MASK  = PORT_W'(18'h3FF0F),
  parameter logic [PORT_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [PORT_W-1:0] oe_bits,
  input  logic [LEN_W-1:0]  phase_len,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_wr_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [PORT_W-1:0] port_dout,
  output logic              busy,
  output logic              err
);
  logic [SEL_W-1:0]  clk_sel;
  logic [SEL_W-1:0]  dat_sel;
  logic [PORT_W-1:0] clk_w;
  logic [PORT_W-1:0] dat_w;
  logic              msb_first;
  logic              cfg_err;
  logic              masks_ok;
  logic              take;
  logic              go;
  logic              ent_lo;
  logic              ent_data;
  logic              ent_hi;
  logic              bit_val;

  generate
    if (PORT_W == SEL_W) begin : g_same
      assign clk_w = clk_sel;
      assign dat_w = dat_sel;
    end else begin : g_ext
      assign clk_w = {{(PORT_W - SEL_W){1'b0}}, clk_sel};
      assign dat_w = {{(PORT_W - SEL_W){1'b0}}, dat_sel};
    end
  endgenerate

  spw_cfg_reg #(.PORT_W(PORT_W), .CHG_MASK(CHG_MASK)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_word  (cfg_word),
    .oe_bits   (oe_bits),
    .busy      (busy),
    .clk_sel   (clk_sel),
    .dat_sel   (dat_sel),
    .msb_first (msb_first),
    .cfg_err   (cfg_err)
  );

  assign masks_ok = (|clk_sel) && (|dat_sel);
  assign take     = in_valid && in_ready;
  assign go       = take && masks_ok;

  spw_bit_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cfg_hold  (cfg_valid),
    .msb_first (msb_first),
    .byte_in   (in_byte),
    .len       (phase_len),
    .ready     (in_ready),
    .busy      (busy),
    .ent_lo    (ent_lo),
    .ent_data  (ent_data),
    .ent_hi    (ent_hi),
    .bit_val   (bit_val)
  );

  // read-modify-write of the selected pins only
  always_ff @(posedge clk) begin
    if (!rst_n)
      port_dout <= RESET_VAL;
    else if (ent_lo)
      port_dout <= port_dout & ~clk_w;
    else if (ent_data)
      port_dout <= bit_val ? (port_dout | dat_w) : (port_dout & ~dat_w);
    else if (ent_hi)
      port_dout <= port_dout | clk_w;
    else if (port_wr && !busy)
      port_dout <= port_wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      err <= 1'b0;
    else
      err <= cfg_err || (take && !masks_ok);
  end
endmodule

// File: rtl/spw_checker.sv
module spw_checker
  import spw_pkg::*;
#(
  parameter int unsigned PORT_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_valid,
  input logic              busy,
  input logic              err,
  input logic [PORT_W-1:0] port_dout,
  input logic [SEL_W-1:0]  clk_sel,
  input logic [SEL_W-1:0]  dat_sel
);
  logic [PORT_W-1:0] ck_w;
  logic [PORT_W-1:0] dt_w;
  logic [PORT_W-1:0] sel_w;

  assign ck_w  = PORT_W'(clk_sel);
  assign dt_w  = PORT_W'(dat_sel);
  assign sel_w = ck_w | dt_w;

  // R11
  cfg_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && busy) |=> err);

  // R4
  zero_mask_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (clk_sel == '0 || dat_sel == '0)) |=> (err && !busy));

  // R7
  keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((port_dout & ~sel_w) == ($past(port_dout) & ~sel_w)));

  // R8
  start_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  // R10
  clk_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((port_dout & ck_w) == ck_w));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((ck_w & dt_w) == '0) && ((port_dout & ck_w) == ck_w) &&
     (($past(port_dout) & ck_w) != ck_w))
    |-> ((port_dout & dt_w) == ($past(port_dout) & dt_w)));
endmodule

bind port_serial_writer spw_checker #(.PORT_W(PORT_W)) u_spw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .cfg_valid (cfg_valid),
  .busy      (busy),
  .err       (err),
  .port_dout (port_dout),
  .clk_sel   (clk_sel),
  .dat_sel   (dat_sel)
);

// File: tb/port_serial_writer_test.sv
`timescale 1ns/100ps
module port_serial_writer_test;
  import spw_pkg::*;

  localparam int unsigned PORT_W = 18;
  localparam int unsigned LEN_W  = 8;
  localparam logic [PORT_W-1:0] CLKM  = 18'h00001;
  localparam logic [PORT_W-1:0] DATM  = 18'h00002;
  localparam logic [PORT_W-1:0] BASE  = 18'h3C0F0;
  localparam logic [PORT_W-1:0] OTHER = ~(CLKM | DATM);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic [CFG_W-1:0]  cfg_word = '0;
  logic [PORT_W-1:0] oe_bits = '1;
  logic [LEN_W-1:0]  phase_len = 8'd1;
  logic              port_wr = 1'b0;
  logic [PORT_W-1:0] port_wr_val = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_byte = '0;
  logic [PORT_W-1:0] port_dout;
  logic              busy;
  logic              err;

  int total = 0;
  int bad   = 0;

  logic [7:0] exp_q[$];
  bit         msb_q[$];

  always #2.5 clk = ~clk;

  port_serial_writer uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .oe_bits(oe_bits), .phase_len(phase_len), .port_wr(port_wr),
    .port_wr_val(port_wr_val), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .port_dout(port_dout), .busy(busy), .err(err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // scoreboard monitor
  bit                mon_on = 1'b0;
  logic [PORT_W-1:0] prev_port = '0;
  logic [7:0]        acc = '0;
  int                nbits = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      check("R7", "untouched port bits", 32'(port_dout & OTHER), 32'(BASE & OTHER));
      if (((prev_port & CLKM) == '0) && ((port_dout & CLKM) == CLKM)) begin
        acc = {acc[6:0], ((port_dout & DATM) != '0)};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            check("R6", "unexpected byte", 32'(acc), 32'hFFFF);
          end else begin
            logic [7:0] eb;
            bit         em;
            eb = exp_q.pop_front();
            em = msb_q.pop_front();
            check("R6", "received byte", 32'(em ? acc : rev8(acc)), 32'(eb));
          end
        end
      end
    end
    prev_port = port_dout;
  end

  task automatic cfg_cycle(input logic [CFG_W-1:0] w);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_word  = w;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic offer_byte(input logic [7:0] b, input bit expect_tx, input bit msb);
    @(negedge clk);
    if (expect_tx) begin
      exp_q.push_back(b);
      msb_q.push_back(msb);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "port after reset", 32'(port_dout), 32'h0);
    check("R1", "busy after reset", 32'(busy), 32'h0);
    check("R1", "ready after reset", 32'(in_ready), 32'h1);
    check("R1", "err after reset", 32'(err), 32'h0);

    // R12 idle port write
    port_wr = 1'b1; port_wr_val = BASE;
    @(negedge clk);
    port_wr = 1'b0;
    check("R12", "port after idle write", 32'(port_dout), 32'(BASE));
    mon_on = 1'b1;

    // R4 byte with no masks
    offer_byte(8'h77, 1'b0, 1'b0);
    check("R4", "err on unconfigured byte", 32'(err), 32'h1);
    check("R4", "busy on unconfigured byte", 32'(busy), 32'h0);
    check("R4", "port on unconfigured byte", 32'(port_dout), 32'(BASE));

    // R3 clock pin not an output
    oe_bits = 18'h3FFFE;
    cfg_cycle(17'h10201);
    check("R3", "err on bad direction", 32'(err), 32'h1);
    offer_byte(8'h11, 1'b0, 1'b0);
    check("R3", "byte refused after reject", 32'(err), 32'h1);
    check("R3", "no transfer after reject", 32'(busy), 32'h0);

    // R2 clock pin not changeable (bit 4 outside mask)
    oe_bits = '1;
    cfg_cycle(17'h10210);
    check("R2", "err on fixed pin", 32'(err), 32'h1);
    cfg_cycle(17'h10201);
    check("R2", "good config accepted", 32'(err), 32'h0);

    // R5/R8/R10 MSB-first, two cycles per phase
    phase_len = 8'd2;
    offer_byte(8'hA5, 1'b1, 1'b1);            // now k=0
    check("R5", "clock low at k0", 32'(port_dout & CLKM), 32'h0);
    check("R5", "data not yet set at k0", 32'(port_dout & DATM), 32'h0);
    repeat (2) @(negedge clk);                // k=2
    check("R5", "data set at k2", 32'(port_dout & DATM), 32'(DATM));
    check("R5", "clock still low at k2", 32'(port_dout & CLKM), 32'h0);
    repeat (2) @(negedge clk);                // k=4
    check("R5", "clock high at k4", 32'(port_dout & CLKM), 32'(CLKM));
    repeat (2) @(negedge clk);                // k=6
    check("R5", "clock low for bit 1", 32'(port_dout & CLKM), 32'h0);
    repeat (40) @(negedge clk);               // k=46
    check("R8", "ready low before final cycle", 32'(in_ready), 32'h0);
    @(negedge clk);                           // k=47
    check("R8", "busy in final cycle", 32'(busy), 32'h1);
    check("R8", "ready in final cycle", 32'(in_ready), 32'h1);
    @(negedge clk);                           // k=48
    check("R8", "idle after 48 cycles", 32'(busy), 32'h0);
    check("R10", "clock high when idle", 32'(port_dout & CLKM), 32'(CLKM));

    // R11 config while busy, R12 write while busy
    offer_byte(8'h5A, 1'b1, 1'b1);
    repeat (9) @(negedge clk);
    cfg_valid = 1'b1; cfg_word = 17'h00102;
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R11", "err on busy config", 32'(err), 32'h1);
    port_wr = 1'b1; port_wr_val = '0;
    @(negedge clk);
    port_wr = 1'b0;
    while (busy) @(negedge clk);
    check("R12", "busy write ignored", 32'(port_dout & OTHER), 32'(BASE & OTHER));

    // R6/R9 LSB-first, back-to-back, zero length acts as one
    cfg_cycle(17'h00201);
    check("R2", "lsb config accepted", 32'(err), 32'h0);
    phase_len = 8'd0;
    @(negedge clk);
    exp_q.push_back(8'h3C); msb_q.push_back(1'b0);
    exp_q.push_back(8'h81); msb_q.push_back(1'b0);
    in_valid = 1'b1; in_byte = 8'h3C;
    @(negedge clk);                           // k=0
    in_byte = 8'h81;
    repeat (23) @(negedge clk);               // k=23
    check("R9", "ready in final cycle", 32'(in_ready), 32'h1);
    check("R5", "zero length: byte spans 24 cycles", 32'(busy), 32'h1);
    @(negedge clk);                           // k=24
    in_valid = 1'b0;
    check("R9", "still busy into next byte", 32'(busy), 32'h1);
    check("R9", "next clock low at once", 32'(port_dout & CLKM), 32'h0);
    @(negedge clk);                           // k=25
    check("R5", "first lsb data bit", 32'(port_dout & DATM), 32'(DATM));
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R6", "all bytes received", 32'(exp_q.size()), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule